// File: doc/BRIEF.md
# Linked-List Sharer Directory

This block keeps coherence sharer lists for a small set of memory lines without a per-line bit vector. For each line, the home side keeps one head pointer. Every node keeps, for each line it caches, a membership flag plus a previous-sharer pointer and a next-sharer pointer. Together these form a doubly linked list of the sharers.

Commands enter on a valid/ready stream: read miss, write miss, evict, or no-op.

- **Read miss:** links the requester in at the head of the list.
- **Evict:** unlinks the node by repairing the pointers of its neighbours.
- **Write miss:** walks the list from head to tail, one node per cycle. It emits one invalidate per sharer on an outgoing valid/ready stream. The walk then leaves the writer as the only sharer.

Invalidation traffic and latency therefore grow with the number of sharers, and there is no broadcast path.

Back-pressure rules:
- A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high.
- `cmd_ready` stays low from the edge that accepts a write miss until the walk has finished.
- An invalidate is consumed on an edge where both `inv_valid` and `inv_ready` are high.
- While `inv_ready` is low, the walk stalls and the offered invalidate holds steady.

Top module: `sharer_list_dir`

## Requirements
- R1: After reset, `cmd_ready` is 1, `inv_valid` and `wr_done` are 0, and every line's list is empty, so a write miss then emits no invalidate.
- R2: A read miss (`cmd_op` = 2'b01) by a non-sharer puts that node at the head. A later walk therefore visits sharers in reverse order of their read misses.
- R3: A read miss by a node that is already a sharer of the line leaves the list unchanged.
- R4: An evict (`cmd_op` = 2'b11) by a sharer removes it from the list, whether it is at the head, in the middle or at the tail. The remaining sharers keep their relative order.
- R5: An evict by a node that is not a sharer of the line has no effect.
- R6: A write miss (`cmd_op` = 2'b10) visits the sharers from head to tail, one per cycle.
  - Each sharer other than the writer is offered as an invalidate, with `inv_node` set to the sharer and `inv_line` set to the line.
  - If the writer is itself a sharer, its visit takes one cycle with no invalidate.
- R7: While `inv_valid` is 1 and `inv_ready` is 0, the next cycle still shows `inv_valid` 1 with unchanged `inv_node` and `inv_line`.
- R8: `wr_done` is 1 for exactly one cycle, the cycle after the last visit. Afterwards the writer is the only sharer of the line.
- R9: `cmd_ready` is 0 from the cycle after a write miss is accepted through the `wr_done` cycle. This is one cycle per list node visited plus one. Commands offered meanwhile wait and are not lost.
- R10: Commands on one line never change the list of another line.
- R11: A no-op command (`cmd_op` = 2'b00) is accepted and changes no list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted on this edge when valid |
| cmd_op | input | 2 | 00 no-op, 01 read miss, 10 write miss, 11 evict |
| cmd_node | input | 2 | Requesting node |
| cmd_line | input | 2 | Line addressed |
| inv_valid | output | 1 | Invalidate offered |
| inv_ready | input | 1 | Invalidate consumed on this edge when valid |
| inv_node | output | 2 | Sharer to invalidate |
| inv_line | output | 2 | Line being invalidated |
| wr_done | output | 1 | One-cycle pulse when a write walk completes |

## Verification
A corrupted pointer or membership flag stays hidden until a write miss walks that line. At that point it shows up at the ports in one of three ways:
- a missing, duplicated or reordered invalidate;
- an invalidate naming the writer;
- a walk whose length differs from the sharer count, which moves `wr_done` and the return of `cmd_ready`.

A wrong head pointer likewise shows up on the first invalidate of the next walk. Faults in the walk sequencing itself appear within one cycle as a mismatch in `cmd_ready`, `inv_valid` or `wr_done`. The bench therefore compares these every cycle and ends each scenario with a write miss that exposes the list contents.

// File: rtl/dirll_pkg.sv
package dirll_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'b00,
    OP_RD  = 2'b01,
    OP_WR  = 2'b10,
    OP_EV  = 2'b11
  } dir_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_st_e;

endpackage

// File: rtl/dirll_head_tbl.sv
module dirll_head_tbl #(
  parameter int LINES = 4,
  parameter int LW    = 2,
  parameter int PW    = 3,
  parameter int NULLP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rd_line,
  output logic [PW-1:0] head_ptr,
  input  logic          we,
  input  logic [PW-1:0] wd
);

  logic [PW-1:0] head_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) head_q[l] <= PW'(NULLP);
    end else if (we) begin
      head_q[rd_line] <= wd;
    end
  end

  assign head_ptr = head_q[rd_line];

endmodule

// File: rtl/dirll_link_store.sv
module dirll_link_store #(
  parameter int NODES = 4,
  parameter int LINES = 4,
  parameter int NW    = 2,
  parameter int LW    = 2,
  parameter int PW    = 3,
  parameter int NULLP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] a_node,
  input  logic [LW-1:0] a_line,
  input  logic [PW-1:0] old_head,
  input  logic          ins_en,
  input  logic          unl_en,
  input  logic          clr_en,
  input  logic          claim_en,
  output logic          q_mem,
  output logic [PW-1:0] q_prv,
  output logic [PW-1:0] q_nxt
);

  logic          mem_q [NODES][LINES];
  logic [PW-1:0] prv_q [NODES][LINES];
  logic [PW-1:0] nxt_q [NODES][LINES];

  assign q_mem = mem_q[a_node][a_line];
  assign q_prv = prv_q[a_node][a_line];
  assign q_nxt = nxt_q[a_node][a_line];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NODES; n++) begin
        for (int l = 0; l < LINES; l++) begin
          mem_q[n][l] <= 1'b0;
          prv_q[n][l] <= PW'(NULLP);
          nxt_q[n][l] <= PW'(NULLP);
        end
      end
    end else begin
      for (int n = 0; n < NODES; n++) begin
        for (int l = 0; l < LINES; l++) begin
          if (l == int'(a_line)) begin
            if (n == int'(a_node)) begin
              if (claim_en) begin
                mem_q[n][l] <= 1'b1;
                prv_q[n][l] <= PW'(NULLP);
                nxt_q[n][l] <= PW'(NULLP);
              end else if (clr_en || unl_en) begin
                mem_q[n][l] <= 1'b0;
              end else if (ins_en) begin
                mem_q[n][l] <= 1'b1;
                prv_q[n][l] <= PW'(NULLP);
                nxt_q[n][l] <= old_head;
              end
            end else begin
              if (ins_en && old_head == PW'(n)) prv_q[n][l] <= PW'(a_node);
              if (unl_en && q_prv == PW'(n))    nxt_q[n][l] <= q_nxt;
              if (unl_en && q_nxt == PW'(n))    prv_q[n][l] <= q_prv;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/dirll_walk_ctrl.sv
module dirll_walk_ctrl
  import dirll_pkg::*;
#(
  parameter int NW    = 2,
  parameter int LW    = 2,
  parameter int PW    = 3,
  parameter int NULLP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [NW-1:0] cmd_node,
  input  logic [LW-1:0] cmd_line,
  output logic          inv_valid,
  input  logic          inv_ready,
  output logic [NW-1:0] inv_node,
  output logic [LW-1:0] inv_line,
  output logic          wr_done,
  input  logic [PW-1:0] head_ptr,
  input  logic          q_mem,
  input  logic [PW-1:0] q_prv,
  input  logic [PW-1:0] q_nxt,
  output logic [NW-1:0] a_node,
  output logic [LW-1:0] a_line,
  output logic          ins_en,
  output logic          unl_en,
  output logic          clr_en,
  output logic          claim_en,
  output logic          head_we,
  output logic [PW-1:0] head_wd
);

  walk_st_e      st_q;
  logic [NW-1:0] writer_q;
  logic [LW-1:0] wline_q;
  logic [PW-1:0] cursor_q;
  logic          idle, fire, cur_null, step, self_visit;

  assign idle       = (st_q == ST_IDLE);
  assign fire       = cmd_valid && idle;
  assign cur_null   = (cursor_q == PW'(NULLP));
  assign self_visit = (cursor_q[NW-1:0] == writer_q);

  assign cmd_ready = idle;
  assign inv_valid = !idle && !cur_null && !self_visit;
  assign inv_node  = cursor_q[NW-1:0];
  assign inv_line  = wline_q;
  assign wr_done   = !idle && cur_null;

  assign a_node = idle ? cmd_node : (cur_null ? writer_q : cursor_q[NW-1:0]);
  assign a_line = idle ? cmd_line : wline_q;

  assign ins_en   = fire && (cmd_op == OP_RD) && !q_mem;
  assign unl_en   = fire && (cmd_op == OP_EV) && q_mem;
  assign step     = !idle && !cur_null && (self_visit || inv_ready);
  assign clr_en   = step;
  assign claim_en = wr_done;

  assign head_we = ins_en || (unl_en && q_prv == PW'(NULLP)) || claim_en;
  assign head_wd = ins_en ? PW'(cmd_node) : (unl_en ? q_nxt : PW'(writer_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      writer_q <= '0;
      wline_q  <= '0;
      cursor_q <= PW'(NULLP);
    end else if (fire && cmd_op == OP_WR) begin
      st_q     <= ST_WALK;
      writer_q <= cmd_node;
      wline_q  <= cmd_line;
      cursor_q <= head_ptr;
    end else if (step) begin
      cursor_q <= q_nxt;
    end else if (wr_done) begin
      st_q     <= ST_IDLE;
      cursor_q <= PW'(NULLP);
    end
  end

  // R7
  inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_node) && $stable(inv_line));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done && cmd_ready);

  // R9
  walk_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == OP_WR |=> !cmd_ready);

  // R6
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_ready |=> !inv_valid || inv_node != $past(inv_node));

endmodule

// File: rtl/sharer_list_dir.sv
module sharer_list_dir #(
  parameter int NODES = 4,
  parameter int LINES = 4,
  localparam int NW    = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int LW    = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int PW    = $clog2(NODES + 1),
  localparam int NULLP = NODES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [NW-1:0] cmd_node,
  input  logic [LW-1:0] cmd_line,
  output logic          inv_valid,
  input  logic          inv_ready,
  output logic [NW-1:0] inv_node,
  output logic [LW-1:0] inv_line,
  output logic          wr_done
);

  logic [PW-1:0] head_ptr, head_wd, q_prv, q_nxt;
  logic [NW-1:0] a_node;
  logic [LW-1:0] a_line;
  logic          q_mem, ins_en, unl_en, clr_en, claim_en, head_we;

  dirll_walk_ctrl #(.NW(NW), .LW(LW), .PW(PW), .NULLP(NULLP)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_node(cmd_node), .cmd_line(cmd_line),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_node(inv_node),
    .inv_line(inv_line), .wr_done(wr_done),
    .head_ptr(head_ptr), .q_mem(q_mem), .q_prv(q_prv), .q_nxt(q_nxt),
    .a_node(a_node), .a_line(a_line),
    .ins_en(ins_en), .unl_en(unl_en), .clr_en(clr_en), .claim_en(claim_en),
    .head_we(head_we), .head_wd(head_wd)
  );

  dirll_head_tbl #(.LINES(LINES), .LW(LW), .PW(PW), .NULLP(NULLP)) u_head (
    .clk(clk), .rst_n(rst_n), .rd_line(a_line), .head_ptr(head_ptr),
    .we(head_we), .wd(head_wd)
  );

  dirll_link_store #(.NODES(NODES), .LINES(LINES), .NW(NW), .LW(LW),
                     .PW(PW), .NULLP(NULLP)) u_links (
    .clk(clk), .rst_n(rst_n), .a_node(a_node), .a_line(a_line),
    .old_head(head_ptr), .ins_en(ins_en), .unl_en(unl_en),
    .clr_en(clr_en), .claim_en(claim_en),
    .q_mem(q_mem), .q_prv(q_prv), .q_nxt(q_nxt)
  );

endmodule

// File: tb/test_sharer_list_dir.sv
module test_sharer_list_dir;

  localparam int NODES = 4;
  localparam int LINES = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [1:0] cmd_node = '0;
  logic [1:0] cmd_line = '0;
  logic       inv_valid;
  logic       inv_ready = 1'b1;
  logic [1:0] inv_node;
  logic [1:0] inv_line;
  logic       wr_done;

  sharer_list_dir #(.NODES(NODES), .LINES(LINES)) i_sharer_list_dir (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_node(cmd_node), .cmd_line(cmd_line),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_node(inv_node),
    .inv_line(inv_line), .wr_done(wr_done)
  );

  always #4 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  int    done_cnt = 0;
  bit    stall  = 0;
  string phase  = "R1";

  // behavioural reference: one queue per line, head at index 0
  int lst [LINES][$];
  bit m_busy = 0;
  int m_visit[$];
  int m_wr = 0;
  int m_wl = 0;
  int cap[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int find_idx(input int l, input int n);
    for (int i = 0; i < lst[l].size(); i++) if (lst[l][i] == n) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (inv_valid && inv_ready) cap.push_back(int'(inv_node));
      if (wr_done) done_cnt++;
      if (m_busy) begin
        if (m_visit.size() > 0) begin
          if (m_visit[0] == m_wr || inv_ready) void'(m_visit.pop_front());
        end else begin
          lst[m_wl].delete();
          lst[m_wl].push_back(m_wr);
          m_busy = 0;
        end
      end else if (cmd_valid) begin
        case (cmd_op)
          2'b01: if (find_idx(int'(cmd_line), int'(cmd_node)) < 0)
                   lst[cmd_line].push_front(int'(cmd_node));
          2'b11: begin
            int k;
            k = find_idx(int'(cmd_line), int'(cmd_node));
            if (k >= 0) lst[cmd_line].delete(k);
          end
          2'b10: begin
            m_busy  = 1;
            m_visit = lst[cmd_line];
            m_wr    = int'(cmd_node);
            m_wl    = int'(cmd_line);
          end
          default: ;
        endcase
      end
      #2;
      begin
        bit e_iv, e_done;
        e_iv   = m_busy && m_visit.size() > 0 && m_visit[0] != m_wr;
        e_done = m_busy && m_visit.size() == 0;
        check(cmd_ready == !m_busy, phase, "cmd_ready", cmd_ready, !m_busy);
        check(inv_valid == e_iv, phase, "inv_valid", inv_valid, e_iv);
        check(wr_done == e_done, phase, "wr_done", wr_done, e_done);
        if (e_iv) begin
          check(int'(inv_node) == m_visit[0], phase, "inv_node", inv_node, m_visit[0]);
          check(int'(inv_line) == m_wl, phase, "inv_line", inv_line, m_wl);
        end
      end
    end
  end

  always @(negedge clk) inv_ready = stall ? (cyc % 3 != 1) : 1'b1;

  always @(posedge clk) begin
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic send(input logic [1:0] op, input int n, input int l);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_node = 2'(n); cmd_line = 2'(l);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic walk_check(input string req, input int w, input int l,
                            input int busy_exp, input int cnt,
                            input int e0, input int e1, input int e2);
    int e[3];
    int busy, d0;
    bit ok;
    e[0] = e0; e[1] = e1; e[2] = e2;
    phase = req;
    cap.delete();
    d0 = done_cnt;
    send(2'b10, w, l);
    busy = 0;
    while (!cmd_ready) begin busy++; @(negedge clk); end
    ok = (cap.size() == cnt);
    for (int i = 0; i < cnt && ok; i++) ok = (cap[i] == e[i]);
    check(ok, req, "invalidate sequence (first node / count)",
          cap.size() > 0 ? cap[0] : -1, cnt > 0 ? e0 : -1);
    check(cap.size() == cnt, req, "invalidate count", cap.size(), cnt);
    check(done_cnt - d0 == 1, "R8", "wr_done pulses", done_cnt - d0, 1);
    if (busy_exp >= 0) check(busy == busy_exp, "R9", "busy cycles", busy, busy_exp);
  endtask

  initial begin
    #1;
    check(cmd_ready == 1'b1 || cmd_ready == 1'b0, "R1", "ready known", cmd_ready, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1", "reset cmd_ready", cmd_ready, 1);
    check(inv_valid == 1'b0, "R1", "reset inv_valid", inv_valid, 0);
    check(wr_done == 1'b0, "R1", "reset wr_done", wr_done, 0);
    // R1: empty list walk
    walk_check("R1", 0, 0, 1, 0, 0, 0, 0);
    // R2: insertion at head, walk order reversed
    phase = "R2";
    send(2'b01, 0, 1); send(2'b01, 1, 1); send(2'b01, 2, 1);
    walk_check("R2", 3, 1, 4, 3, 2, 1, 0);
    // R3: repeated read miss
    phase = "R3";
    send(2'b01, 1, 2); send(2'b01, 2, 2); send(2'b01, 1, 2);
    walk_check("R3", 0, 2, 3, 2, 2, 1, 0);
    // R4: middle unlink, writer is a sharer (R6 silent visit)
    phase = "R4";
    send(2'b01, 0, 3); send(2'b01, 1, 3); send(2'b01, 2, 3); send(2'b01, 3, 3);
    send(2'b11, 2, 3);
    walk_check("R4", 0, 3, 4, 2, 3, 1, 0);
    // R4: head and tail unlink
    send(2'b01, 0, 1); send(2'b01, 1, 1);
    send(2'b11, 1, 1); send(2'b11, 3, 1);
    send(2'b01, 2, 1);
    walk_check("R4", 3, 1, 3, 2, 2, 0, 0);
    // R5: evict by non-sharer
    phase = "R5";
    send(2'b11, 1, 0);
    walk_check("R5", 2, 0, 2, 1, 0, 0, 0);
    // R7: back-pressure on invalidates, R6 skip of writer
    phase = "R7";
    send(2'b01, 1, 2); send(2'b01, 2, 2); send(2'b01, 3, 2);
    stall = 1;
    walk_check("R7", 1, 2, -1, 3, 3, 2, 0);
    stall = 0;
    // R10: line independence
    phase = "R10";
    send(2'b01, 1, 0);
    walk_check("R10", 2, 3, 2, 1, 0, 0, 0);
    walk_check("R10", 3, 0, 3, 2, 1, 2, 0);
    // R11: no-op
    phase = "R11";
    send(2'b00, 0, 0);
    walk_check("R11", 0, 0, 2, 1, 3, 0, 0);
    // R9: command offered during a walk waits
    phase = "R9";
    cap.delete();
    send(2'b10, 0, 1);
    send(2'b01, 2, 1);
    check(cap.size() == 1 && cap[0] == 3, "R9", "walk before queued read",
          cap.size() > 0 ? cap[0] : -1, 3);
    walk_check("R9", 1, 1, 3, 2, 2, 0, 0);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule